// File: doc/BRIEF.md
# Floating-Point Issue Interlock Scoreboard

This block sits at the issue point of a floating-point coprocessor and decides, every cycle, whether the operation offered there may go. The coprocessor has four kinds of resource: a multiply-add pipe, a divide/square-root pipe, a flag-transfer path, and a load/store path of three stages. Each operation class claims some of these resources over the next few cycles. The block keeps a short reservation window per resource. It refuses an operation whose claims overlap a reservation that is already held.

Alongside the reservations it keeps one countdown per architectural register, giving the number of cycles until the pending result can be read. An arithmetic result consumed by another arithmetic operation is forwarded one cycle early. A flag transfer is serialising and waits until the multiply-add and divide pipes hold no reservations at all. A held first execute stage in the host core blocks every issue.

The output `stall` is combinational, so the issuing stage can use it in the same cycle. A stalled offer leaves no trace in the block's state.

Top module: `fpil_issue_scoreboard`

## Requirements
- R1: With `issue_valid` low, `stall` is low. After reset no reservation or pending result exists, so any offered class issues at once when `core_hold` is low.
- R2: When `issue_valid` and `core_hold` are both high, `stall` is high, whatever the class.
- R3: The multiply-add pipe is claimed for one cycle by class 0 (add/compare/convert/move), for two consecutive cycles by class 1 (multiply, multiply-add), and in the first cycle by class 3 (double divide/root). An offer whose claim overlaps a held cycle stalls.
- R4: The divide pipe is claimed for four consecutive cycles by class 2 (single divide/root) and by class 3. An overlapping offer stalls.
- R5: Class 4 (single load) claims load/store stage 1 in its first cycle and stage 2 in its second. Class 5 (double load) claims stages 1, 2 and 3 in its first cycle, stages 2 and 3 in its second, and stage 3 in its third. So a class 5 offered right after a class 4 stalls once, and a class 5 offered right after a class 5 stalls twice.
- R6: Classes 0 to 5 write `dst`. Their result latencies are 5, 6, 18, 32, 4 and 5 cycles. Classes 0 to 3 read `src_a` and `src_b`, and stall until every source's latency has elapsed since its producer issued.
- R7: When both producer and consumer are in classes 0 to 3, the source is readable one cycle earlier than its latency. A load producer (class 4 or 5) gets no such reduction.
- R8: Class 6 (flag transfer) stalls while the multiply-add or divide pipe holds any reservation. It reads and writes no registers.
- R9: A stalled offer records neither reservations nor a destination.
- R10: Class 7 claims no resource and no register, and stalls only under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is offered this cycle |
| core_hold | input | 1 | Host core's first execute stage is held |
| op_class | input | 3 | Operation class code, 0 to 7 |
| src_a | input | 5 | First source register |
| src_b | input | 5 | Second source register |
| dst | input | 5 | Destination register |
| stall | output | 1 | The offered operation may not issue this cycle |

## Verification
A structural conflict and a read-after-write wait can hold the same offer in the same cycle. This happens, for example, when a multiply is followed at once by an add that reads the multiply's result. Only after both clear may the offer issue. The random phase draws registers from a set of six and classes from all eight codes, so such coincidences, and flag transfers meeting live divides, occur often. A bench model built on absolute cycle numbers judges each cycle. Each mismatch is attributed to the first cause in priority order: hold, drain, unit, operand.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

  typedef enum logic [2:0] {
    OP_ADDLIKE  = 3'd0,
    OP_MULLIKE  = 3'd1,
    OP_DIV_SP   = 3'd2,
    OP_DIV_DP   = 3'd3,
    OP_LD_SP    = 3'd4,
    OP_LD_DP    = 3'd5,
    OP_FLAGXFER = 3'd6,
    OP_NONE     = 3'd7
  } op_cls_e;

  localparam int NUM_UNITS = 5;
  localparam int U_MAC = 0;
  localparam int U_DIV = 1;
  localparam int U_LS1 = 2;
  localparam int U_LS2 = 3;
  localparam int U_LS3 = 4;

endpackage

// File: rtl/fpil_class_decode.sv
module fpil_class_decode
  import fpil_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int LAT_W    = 6,
  parameter int LAT_ADD  = 5,
  parameter int LAT_MUL  = 6,
  parameter int LAT_DIVS = 18,
  parameter int LAT_DIVD = 32,
  parameter int LAT_LDS  = 4,
  parameter int LAT_LDD  = 5
) (
  input  logic [2:0]                       op_i,
  output logic [NUM_UNITS-1:0][DEPTH-1:0]  pat_o,
  output logic                             reads_o,
  output logic                             writes_o,
  output logic                             arith_o,
  output logic                             flag_o,
  output logic [LAT_W-1:0]                 lat_m1_o
);

  always_comb begin
    pat_o    = '0;
    reads_o  = 1'b0;
    writes_o = 1'b0;
    arith_o  = 1'b0;
    flag_o   = 1'b0;
    lat_m1_o = '0;
    case (op_cls_e'(op_i))
      OP_ADDLIKE: begin
        pat_o[U_MAC][0] = 1'b1;
        reads_o  = 1'b1;
        writes_o = 1'b1;
        arith_o  = 1'b1;
        lat_m1_o = LAT_W'(LAT_ADD - 1);
      end
      OP_MULLIKE: begin
        pat_o[U_MAC][1:0] = 2'b11;
        reads_o  = 1'b1;
        writes_o = 1'b1;
        arith_o  = 1'b1;
        lat_m1_o = LAT_W'(LAT_MUL - 1);
      end
      OP_DIV_SP: begin
        pat_o[U_DIV][3:0] = 4'b1111;
        reads_o  = 1'b1;
        writes_o = 1'b1;
        arith_o  = 1'b1;
        lat_m1_o = LAT_W'(LAT_DIVS - 1);
      end
      OP_DIV_DP: begin
        pat_o[U_MAC][0]   = 1'b1;
        pat_o[U_DIV][3:0] = 4'b1111;
        reads_o  = 1'b1;
        writes_o = 1'b1;
        arith_o  = 1'b1;
        lat_m1_o = LAT_W'(LAT_DIVD - 1);
      end
      OP_LD_SP: begin
        pat_o[U_LS1][0] = 1'b1;
        pat_o[U_LS2][1] = 1'b1;
        writes_o = 1'b1;
        lat_m1_o = LAT_W'(LAT_LDS - 1);
      end
      OP_LD_DP: begin
        pat_o[U_LS1][0]   = 1'b1;
        pat_o[U_LS2][1:0] = 2'b11;
        pat_o[U_LS3][2:0] = 3'b111;
        writes_o = 1'b1;
        lat_m1_o = LAT_W'(LAT_LDD - 1);
      end
      OP_FLAGXFER: flag_o = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/fpil_unit_track.sv
module fpil_unit_track #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_i,
  input  logic [DEPTH-1:0] pat_i,
  output logic             conflict_o,
  output logic             pending_o
);

  // bit k set: the unit is taken k cycles from now
  logic [DEPTH-1:0] resv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      resv_q <= '0;
    end else begin
      resv_q <= (resv_q | (fire_i ? pat_i : '0)) >> 1;
    end
  end

  assign conflict_o = |(resv_q & pat_i);
  assign pending_o  = |resv_q;

endmodule

// File: rtl/fpil_reg_ready.sv
module fpil_reg_ready #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5,
  parameter int LAT_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [LAT_W-1:0] wr_lat_m1_i,
  input  logic             wr_fwd_i,
  input  logic             consumer_arith_i,
  input  logic [IDX_W-1:0] src_a_i,
  input  logic [IDX_W-1:0] src_b_i,
  output logic             ready_a_o,
  output logic             ready_b_o
);

  logic [NUM_REGS-1:0][LAT_W-1:0] cnt_q;
  logic [NUM_REGS-1:0]            fwd_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[g] <= '0;
        fwd_q[g] <= 1'b0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        cnt_q[g] <= wr_lat_m1_i;
        fwd_q[g] <= wr_fwd_i;
      end else if (cnt_q[g] != '0) begin
        cnt_q[g] <= cnt_q[g] - LAT_W'(1);
      end
    end
  end

  logic [LAT_W-1:0] cnt_a, cnt_b;

  always_comb begin
    cnt_a     = cnt_q[src_a_i];
    cnt_b     = cnt_q[src_b_i];
    ready_a_o = (cnt_a == '0) ||
                (consumer_arith_i && fwd_q[src_a_i] && (cnt_a == LAT_W'(1)));
    ready_b_o = (cnt_b == '0) ||
                (consumer_arith_i && fwd_q[src_b_i] && (cnt_b == LAT_W'(1)));
  end

endmodule

// File: rtl/fpil_issue_scoreboard.sv
module fpil_issue_scoreboard
  import fpil_pkg::*;
#(
  parameter int  NUM_REGS    = 32,
  parameter int  RESV_DEPTH  = 4,
  parameter int  LAT_ADD     = 5,
  parameter int  LAT_MUL     = 6,
  parameter int  LAT_DIVS    = 18,
  parameter int  LAT_DIVD    = 32,
  parameter int  LAT_LDS     = 4,
  parameter int  LAT_LDD     = 5,
  localparam int IDX_W       = $clog2(NUM_REGS),
  localparam int LAT_W       = $clog2(LAT_DIVD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic             core_hold,
  input  logic [2:0]       op_class,
  input  logic [IDX_W-1:0] src_a,
  input  logic [IDX_W-1:0] src_b,
  input  logic [IDX_W-1:0] dst,
  output logic             stall
);

  // units a flag transfer must see empty
  localparam logic [NUM_UNITS-1:0] DRAIN_MASK =
    NUM_UNITS'((1 << U_MAC) | (1 << U_DIV));

  logic [NUM_UNITS-1:0][RESV_DEPTH-1:0] pat;
  logic                                 reads, writes, arith, is_flag;
  logic [LAT_W-1:0]                     lat_m1;
  logic [NUM_UNITS-1:0]                 unit_conflict, unit_pending;
  logic                                 ready_a, ready_b;
  logic                                 struct_hit, drain_block, raw_hit, fire;

  fpil_class_decode #(
    .DEPTH   (RESV_DEPTH),
    .LAT_W   (LAT_W),
    .LAT_ADD (LAT_ADD),
    .LAT_MUL (LAT_MUL),
    .LAT_DIVS(LAT_DIVS),
    .LAT_DIVD(LAT_DIVD),
    .LAT_LDS (LAT_LDS),
    .LAT_LDD (LAT_LDD)
  ) u_decode (
    .op_i    (op_class),
    .pat_o   (pat),
    .reads_o (reads),
    .writes_o(writes),
    .arith_o (arith),
    .flag_o  (is_flag),
    .lat_m1_o(lat_m1)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    fpil_unit_track #(.DEPTH(RESV_DEPTH)) u_track (
      .clk       (clk),
      .rst       (rst),
      .fire_i    (fire),
      .pat_i     (pat[u]),
      .conflict_o(unit_conflict[u]),
      .pending_o (unit_pending[u])
    );
  end

  fpil_reg_ready #(
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W),
    .LAT_W   (LAT_W)
  ) u_ready (
    .clk             (clk),
    .rst             (rst),
    .wr_en_i         (fire && writes),
    .wr_idx_i        (dst),
    .wr_lat_m1_i     (lat_m1),
    .wr_fwd_i        (arith),
    .consumer_arith_i(arith),
    .src_a_i         (src_a),
    .src_b_i         (src_b),
    .ready_a_o       (ready_a),
    .ready_b_o       (ready_b)
  );

  assign struct_hit  = |unit_conflict;
  assign drain_block = is_flag && |(unit_pending & DRAIN_MASK);
  assign raw_hit     = reads && !(ready_a && ready_b);
  assign stall       = issue_valid &&
                       (core_hold || struct_hit || drain_block || raw_hit);
  assign fire        = issue_valid && !stall;

endmodule

// File: rtl/fpil_sb_checker.sv
module fpil_sb_checker #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_valid,
  input logic             core_hold,
  input logic [2:0]       op_class,
  input logic [IDX_W-1:0] src_a,
  input logic [IDX_W-1:0] dst,
  input logic             stall
);

  logic fire_obs;
  assign fire_obs = issue_valid && !stall;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> !stall);

  // R2
  hold_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && core_hold) |-> stall);

  // R3
  mac_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fire_obs && op_class == 3'd1) && issue_valid &&
     (op_class inside {3'd0, 3'd1, 3'd3})) |-> stall);

  // R5
  ldd_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fire_obs && op_class == 3'd5) && issue_valid &&
     op_class == 3'd5) |-> stall);

  // R8
  flag_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fire_obs && (op_class inside {3'd2, 3'd3})) &&
     issue_valid && op_class == 3'd6) |-> stall);

  // R6
  raw_next_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fire_obs && op_class <= 3'd5) && issue_valid &&
     op_class <= 3'd3 && src_a == $past(dst)) |-> stall);

endmodule

bind fpil_issue_scoreboard fpil_sb_checker #(.IDX_W(IDX_W)) u_sb_checker (
  .clk        (clk),
  .rst        (rst),
  .issue_valid(issue_valid),
  .core_hold  (core_hold),
  .op_class   (op_class),
  .src_a      (src_a),
  .dst        (dst),
  .stall      (stall)
);

// File: tb/tb_fpil_issue_scoreboard.sv
`timescale 1ns/100ps
module tb_fpil_issue_scoreboard;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue_valid = 1'b0;
  logic       core_hold = 1'b0;
  logic [2:0] op_class = 3'd7;
  logic [4:0] src_a = '0, src_b = '0, dst = '0;
  logic       stall;

  always #2 clk = ~clk;  // 250 MHz

  fpil_issue_scoreboard dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .core_hold(core_hold),
    .op_class(op_class), .src_a(src_a), .src_b(src_b), .dst(dst), .stall(stall)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int now      = 0;
  int rdy [32];
  bit fw  [32];
  int held [5][8];   // absolute cycle that owns each slot of each unit

  function automatic bit claims(int cls, int u, int k);
    case (cls)
      0: return (u == 0 && k == 0);
      1: return (u == 0 && k < 2);
      2: return (u == 1 && k < 4);
      3: return (u == 0 && k == 0) || (u == 1 && k < 4);
      4: return (u == 2 && k == 0) || (u == 3 && k == 1);
      5: return (u == 2 && k == 0) || (u == 3 && k < 2) || (u == 4 && k < 3);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int latency(int cls);
    case (cls)
      0: return 5;  1: return 6;  2: return 18;
      3: return 32; 4: return 4;  5: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit src_wait(int s, bit arith_cons);
    int avail;
    avail = rdy[s] - ((arith_cons && fw[s]) ? 1 : 0);
    return now < avail;
  endfunction

  function automatic bit model_stall(bit v, int cls, int a, int b, bit h,
                                     output string why);
    why = (cls == 7) ? "R10" : "R1";
    if (!v) return 1'b0;
    if (h) begin why = "R2"; return 1'b1; end
    if (cls == 6) begin
      for (int u = 0; u < 2; u++)
        for (int k = 0; k < 4; k++)
          if (held[u][(now + k) % 8] == now + k) begin why = "R8"; return 1'b1; end
    end
    for (int u = 0; u < 5; u++)
      for (int k = 0; k < 4; k++)
        if (claims(cls, u, k) && held[u][(now + k) % 8] == now + k) begin
          why = (u == 0) ? "R3" : (u == 1) ? "R4" : "R5";
          return 1'b1;
        end
    if (cls <= 3) begin
      if (src_wait(a, 1'b1) || src_wait(b, 1'b1)) begin
        why = (fw[a] || fw[b]) ? "R7" : "R6";
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic step(input bit v, input int cls, input int a, input int b,
                      input int d, input bit h, input string tag);
    bit    exp;
    string why;
    @(posedge clk);
    #0.5;
    issue_valid = v; op_class = cls[2:0]; src_a = a[4:0]; src_b = b[4:0];
    dst = d[4:0]; core_hold = h;
    exp = model_stall(v, cls, a, b, h, why);
    if (tag != "") why = tag;
    #1;
    n_checks++;
    if (stall !== exp) begin
      n_fail++;
      $display("FAIL %s: stall=%0b expected %0b (cycle %0d class %0d)",
               why, stall, exp, now, cls);
    end
    if (v && !exp) begin
      for (int u = 0; u < 5; u++)
        for (int k = 0; k < 4; k++)
          if (claims(cls, u, k)) held[u][(now + k) % 8] = now + k;
      if (cls <= 5) begin
        rdy[d] = now + latency(cls);
        fw[d]  = (cls <= 3);
      end
    end
    now++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 7, 0, 0, 0, 0, "R1");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin rdy[i] = 0; fw[i] = 0; end
    for (int u = 0; u < 5; u++) for (int s = 0; s < 8; s++) held[u][s] = -1;
    void'($urandom(32'd7351));
    repeat (4) @(posedge clk);
    #0.5 rst = 1'b0;

    // reset state and first issue
    idle(1);
    step(1, 0, 1, 2, 3, 0, "R1");
    // R2 hold blocks a multiply; R9 the held one leaves no trace
    step(1, 1, 10, 11, 12, 1, "R2");
    step(1, 0, 12, 12, 13, 0, "R9");
    idle(6);
    // R3 multiply holds the multiply-add pipe for two cycles
    step(1, 1, 1, 2, 14, 0, "R3");
    step(1, 0, 1, 2, 15, 0, "R3");
    step(1, 0, 1, 2, 15, 0, "R3");
    idle(6);
    // R4 divide pipe four cycles, then R8 flag waits for drain
    step(1, 2, 1, 2, 16, 0, "R4");
    for (int i = 0; i < 4; i++) step(1, 2, 1, 2, 17, 0, "R4");
    for (int i = 0; i < 4; i++) step(1, 6, 16, 17, 0, 0, "R8");
    step(1, 6, 0, 0, 0, 0, "R8");
    idle(6);
    // R5 single then double load, then double after double
    step(1, 4, 0, 0, 18, 0, "R5");
    step(1, 5, 0, 0, 19, 0, "R5");
    step(1, 5, 0, 0, 19, 0, "R5");
    for (int i = 0; i < 3; i++) step(1, 5, 0, 0, 20, 0, "R5");
    idle(6);
    // R6 load result read by an add: four-cycle wait
    step(1, 4, 0, 0, 21, 0, "R6");
    for (int i = 0; i < 4; i++) step(1, 0, 21, 1, 24, 0, "R6");
    idle(6);
    // R7 add to add forwarded; double load to add not forwarded
    step(1, 0, 1, 2, 22, 0, "R7");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 22, 25, 0, "R7");
    idle(6);
    step(1, 5, 0, 0, 23, 0, "R7");
    for (int i = 0; i < 5; i++) step(1, 0, 23, 1, 26, 0, "R7");
    idle(6);
    // R10 class 7 passes a busy multiply-add pipe
    step(1, 1, 1, 2, 27, 0, "R10");
    step(1, 7, 27, 27, 27, 0, "R10");
    step(1, 7, 0, 0, 0, 1, "R2");
    idle(40);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, $urandom % 8, $urandom % 6, $urandom % 6,
           $urandom % 6, ($urandom % 10) == 0, "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule